// File: doc/BRIEF.md
# Shared Control Register Bank

This block is a control register file of 32 words, each 25 bits wide. Two hosts reach it through separate register ports. The primary port has full privilege. The secondary port can read every register but can write only some of them. A constant parameter holds one protection bit per address, and a set bit makes that register writable from the primary port only. Each port has an address, write data, a write strobe, a read strobe and a read data bus. Writes commit on the clock edge that samples the strobe. Read data appears on the cycle after the read strobe.

Register 0x00 holds interrupt status. Hardware sets its bits through a set input, and software clears them by writing ones. Register 0x07 holds an auxiliary regulator code in its low four bits. The code N selects 0.6 V + N × 0.2 V. The secondary port cannot place that code below 3 (1.2 V): a lower code written from that port is stored as 3. The primary port may still write any code. When both ports write the same address in the same cycle, the primary write is stored, the secondary write is dropped, and the secondary port sees a one-cycle collision flag.

Top module: `shared_ctrl_regbank`

## Requirements
- R1: After reset every register reads zero, except address 0x07, which reads 0x3. The collision flag and both read buses are zero.
- R2: A read strobe returns the addressed register on the next cycle, zero-extended to 32 bits so that bits 31..25 are zero. Without a strobe the read bus holds its value.
- R3: A write from either port to an unprotected address other than 0x00 stores the 25-bit write data.
- R4: With the default map, addresses 0x01, 0x04 and 0x1C to 0x1F are primary-only. A secondary write to them leaves the register unchanged, and a primary write to them stores its data.
- R5: At address 0x00, each write-data bit set to 1 clears that status bit, from either port. Each bit set on the status-set input sets that status bit. A set on the same cycle as a clear wins.
- R6: A secondary write to 0x07 whose bits 3..0 hold a code below 3 stores code 3 in bits 3..0 and stores bits 24..4 as written. A code of 3 or more is stored as written.
- R7: A primary write to 0x07 stores bits 3..0 unchanged, including codes below 3.
- R8: When both ports write the same address in one cycle, the primary data is stored and the collision flag is high for exactly the next cycle.
- R9: When both ports write different addresses in one cycle, both writes are stored and the collision flag stays low.
- R10: A read and a write to the same address in one cycle return the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| isr_set | input | 25 | Hardware set bits for the status register |
| p_addr | input | 5 | Primary port address |
| p_wdata | input | 25 | Primary port write data |
| p_we | input | 1 | Primary port write strobe |
| p_re | input | 1 | Primary port read strobe |
| p_rdata | output | 32 | Primary port read data |
| s_addr | input | 5 | Secondary port address |
| s_wdata | input | 25 | Secondary port write data |
| s_we | input | 1 | Secondary port write strobe |
| s_re | input | 1 | Secondary port read strobe |
| s_rdata | output | 32 | Secondary port read data |
| s_collide | output | 1 | Secondary write lost to a primary write on the previous cycle |

## Verification
Two kinds of event can land on the same edge. The first is a write from each port. The bench drives both ports on one falling edge, once to the same address and once to different addresses. It then reads the stored words back and samples the collision flag on the next falling edge and on the one after. The second is a hardware status set that meets a write-one-to-clear on the same bit, and there the bench expects the set to win.

// File: rtl/shared_ctrl_regbank.sv
module shared_ctrl_regbank #(
  parameter int NREG = 32,
  parameter int DW = 25,
  parameter int RDW = 32,
  parameter logic [NREG-1:0] PROT_MAP = 'hF000_0012,
  parameter int ISR_ADDR = 0,
  parameter int VREG_ADDR = 7,
  parameter int FIELD_LSB = 0,
  parameter int FIELD_W = 4,
  parameter int MIN_CODE = 3,
  localparam int AW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  isr_set,
  input  logic [AW-1:0]  p_addr,
  input  logic [DW-1:0]  p_wdata,
  input  logic           p_we,
  input  logic           p_re,
  output logic [RDW-1:0] p_rdata,
  input  logic [AW-1:0]  s_addr,
  input  logic [DW-1:0]  s_wdata,
  input  logic           s_we,
  input  logic           s_re,
  output logic [RDW-1:0] s_rdata,
  output logic           s_collide
);

  localparam logic [DW-1:0] VREG_RST = DW'(MIN_CODE) << FIELD_LSB;
  localparam logic [AW-1:0] ISR_A = AW'(ISR_ADDR);
  localparam logic [AW-1:0] VREG_A = AW'(VREG_ADDR);

  logic [DW-1:0] mem [NREG];
  logic [DW-1:0] p_rd_q, s_rd_q;

  wire same_addr = p_we && s_we && (p_addr == s_addr);
  wire s_allowed = s_we && !PROT_MAP[s_addr] && !same_addr;

  function automatic logic [DW-1:0] raise_code(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    r = v;
    if (v[FIELD_LSB +: FIELD_W] < FIELD_W'(MIN_CODE))
      r[FIELD_LSB +: FIELD_W] = FIELD_W'(MIN_CODE);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++)
        mem[i] <= (i == VREG_ADDR) ? VREG_RST : '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (i == ISR_ADDR) begin
          if (p_we && p_addr == AW'(i))
            mem[i] <= (mem[i] & ~p_wdata) | isr_set;
          else if (s_allowed && s_addr == AW'(i))
            mem[i] <= (mem[i] & ~s_wdata) | isr_set;
          else
            mem[i] <= mem[i] | isr_set;
        end else if (p_we && p_addr == AW'(i)) begin
          mem[i] <= p_wdata;
        end else if (s_allowed && s_addr == AW'(i)) begin
          mem[i] <= (i == VREG_ADDR) ? raise_code(s_wdata) : s_wdata;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_rd_q    <= '0;
      s_rd_q    <= '0;
      s_collide <= 1'b0;
    end else begin
      if (p_re) p_rd_q <= mem[p_addr];
      if (s_re) s_rd_q <= mem[s_addr];
      s_collide <= same_addr;
    end
  end

  assign p_rdata = RDW'(p_rd_q);
  assign s_rdata = RDW'(s_rd_q);

  AST_RD_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    p_re |=> (p_rdata[DW-1:0] == $past(mem[p_addr])) && (p_rdata[RDW-1:DW] == '0)); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !s_re |=> $stable(s_rdata)); // R2
  AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (s_we && PROT_MAP[s_addr] && !(p_we && p_addr == s_addr) && s_addr != ISR_A)
      |=> mem[$past(s_addr)] == $past(mem[s_addr])); // R4
  AST_ISR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (p_we && p_addr == ISR_A && isr_set == '0)
      |=> mem[ISR_ADDR] == ($past(mem[ISR_ADDR]) & ~$past(p_wdata))); // R5
  AST_CODE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (s_we && s_addr == VREG_A && !PROT_MAP[VREG_ADDR] && !(p_we && p_addr == VREG_A))
      |=> mem[VREG_ADDR][FIELD_LSB +: FIELD_W] >= FIELD_W'(MIN_CODE)); // R6
  AST_PRI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (p_we && s_we && p_addr == s_addr && p_addr != ISR_A)
      |=> s_collide && mem[$past(p_addr)] == $past(p_wdata)); // R8

endmodule

// File: tb/tb_shared_ctrl_regbank.sv
`timescale 1ns/1ps
module tb_shared_ctrl_regbank;
  logic clk = 0, rst_n = 0;
  logic [24:0] isr_set = '0;
  logic [4:0]  p_addr = '0, s_addr = '0;
  logic [24:0] p_wdata = '0, s_wdata = '0;
  logic p_we = 0, p_re = 0, s_we = 0, s_re = 0;
  logic [31:0] p_rdata, s_rdata;
  logic s_collide;
  int tests = 0, fails = 0;
  logic [31:0] rd;

  always #4 clk = ~clk;

  shared_ctrl_regbank dut (.clk, .rst_n, .isr_set, .p_addr, .p_wdata, .p_we, .p_re,
    .p_rdata, .s_addr, .s_wdata, .s_we, .s_re, .s_rdata, .s_collide);

  typedef struct packed { logic sec; logic [4:0] addr; logic [24:0] wd; logic [24:0] exp; logic [7:0] req; } vec_t;
  localparam vec_t VECS [11] = '{
    '{1'b0, 5'h02, 25'h1ABCDE,   25'h1ABCDE,   8'd3},  // R3
    '{1'b1, 5'h03, 25'h0F0F0F,   25'h0F0F0F,   8'd3},  // R3
    '{1'b1, 5'h01, 25'h123456,   25'h000000,   8'd4},  // R4
    '{1'b0, 5'h01, 25'h155555,   25'h155555,   8'd4},  // R4
    '{1'b1, 5'h04, 25'h1FFFFFF,  25'h000000,   8'd4},  // R4
    '{1'b1, 5'h07, 25'h0000A1,   25'h0000A3,   8'd6},  // R6
    '{1'b1, 5'h07, 25'h0000A5,   25'h0000A5,   8'd6},  // R6
    '{1'b0, 5'h07, 25'h000040,   25'h000040,   8'd7},  // R7
    '{1'b1, 5'h1F, 25'h000001,   25'h000000,   8'd4},  // R4
    '{1'b0, 5'h1F, 25'h1FFFFFF,  25'h1FFFFFF,  8'd4},  // R4
    '{1'b1, 5'h07, 25'h1FFFFF0,  25'h1FFFFF3,  8'd6}   // R6
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sec, input logic [4:0] a, input logic [24:0] d);
    @(negedge clk);
    if (sec) begin s_we = 1; s_addr = a; s_wdata = d; end
    else     begin p_we = 1; p_addr = a; p_wdata = d; end
    @(negedge clk);
    p_we = 0; s_we = 0;
  endtask

  task automatic rdp(input logic sec, input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    if (sec) begin s_re = 1; s_addr = a; end
    else     begin p_re = 1; p_addr = a; end
    @(negedge clk);
    p_re = 0; s_re = 0;
    v = sec ? s_rdata : p_rdata;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 collide", {31'd0, s_collide}, 32'd0);
    chk("R1 prdata", p_rdata, 32'd0);
    rst_n = 1;
    for (int a = 0; a < 32; a++) begin
      rdp(a[0], a[4:0], rd);
      chk($sformatf("R1 addr %0d", a), rd, (a == 7) ? 32'h3 : 32'h0);
    end

    for (int i = 0; i < 11; i++) begin
      wr(VECS[i].sec, VECS[i].addr, VECS[i].wd);
      rdp(~VECS[i].sec, VECS[i].addr, rd);
      chk($sformatf("R%0d vec %0d", VECS[i].req, i), rd, {7'd0, VECS[i].exp});
    end

    // R2: upper bits zero and hold without strobe
    rdp(0, 5'h1F, rd);
    chk("R2 zero-extend", p_rdata, 32'h01FFFFFF);
    wr(0, 5'h1F, 25'h0);
    repeat (2) @(negedge clk);
    chk("R2 hold", p_rdata, 32'h01FFFFFF);

    // R10: read and write same address same cycle
    @(negedge clk);
    p_we = 1; p_re = 1; p_addr = 5'h02; p_wdata = 25'h000777;
    @(negedge clk);
    p_we = 0; p_re = 0;
    chk("R10 old value", p_rdata, 32'h001ABCDE);
    rdp(1, 5'h02, rd);
    chk("R10 new value", rd, 32'h00000777);

    // R5: status set and write-one-to-clear
    @(negedge clk); isr_set = 25'h0F0;
    @(negedge clk); isr_set = '0;
    rdp(0, 5'h00, rd); chk("R5 set", rd, 32'h0F0);
    wr(0, 5'h00, 25'h030);
    rdp(0, 5'h00, rd); chk("R5 primary clear", rd, 32'h0C0);
    wr(1, 5'h00, 25'h040);
    rdp(1, 5'h00, rd); chk("R5 secondary clear", rd, 32'h080);
    @(negedge clk);
    isr_set = 25'h080; p_we = 1; p_addr = 5'h00; p_wdata = 25'h080;
    @(negedge clk);
    isr_set = '0; p_we = 0;
    rdp(0, 5'h00, rd); chk("R5 set beats clear", rd, 32'h080);

    // R8: same-address collision
    @(negedge clk);
    p_we = 1; p_addr = 5'h05; p_wdata = 25'h111;
    s_we = 1; s_addr = 5'h05; s_wdata = 25'h222;
    @(negedge clk);
    p_we = 0; s_we = 0;
    chk("R8 flag high", {31'd0, s_collide}, 32'd1);
    @(negedge clk);
    chk("R8 flag one cycle", {31'd0, s_collide}, 32'd0);
    rdp(1, 5'h05, rd); chk("R8 primary stored", rd, 32'h111);

    // R9: different addresses
    @(negedge clk);
    p_we = 1; p_addr = 5'h08; p_wdata = 25'hAAA;
    s_we = 1; s_addr = 5'h09; s_wdata = 25'hBBB;
    @(negedge clk);
    p_we = 0; s_we = 0;
    chk("R9 no flag", {31'd0, s_collide}, 32'd0);
    rdp(0, 5'h08, rd); chk("R9 primary", rd, 32'hAAA);
    rdp(0, 5'h09, rd); chk("R9 secondary", rd, 32'hBBB);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule